// File: doc/BRIEF.md
# Converter Result Byte-Pair Register with Read Interlock

This block stores the 10-bit output of an analog-to-digital converter and lets a processor read it as two byte-wide registers on a simple read-only peripheral bus. The upper byte sits at a base address. The lower byte sits at the next address. A justification input chooses how the 10 bits are spread over the two bytes. A one-cycle completion strobe with a 10-bit value loads a new result.

Software reads the upper byte first and the lower byte second. The upper-byte read closes an interlock. While the interlock is closed, the stored value cannot change, so both halves always belong to the same conversion. Any result that arrives while the interlock is closed is discarded. The lower-byte read opens the interlock again. The raw 10-bit value is stored as it arrives and is formatted only when it is read, so a change of justification takes effect on the next read.

Top module: `adc_result_pair`

## Requirements
- R1: With `just_right` = 0, a read of the upper address returns result bits 9..2 in data bits 7..0.
- R2: With `just_right` = 0, a read of the lower address returns result bits 1..0 in data bits 7..6 and 0 in data bits 5..0.
- R3: With `just_right` = 1, a read of the upper address returns 0 in data bits 7..2 and result bits 9..8 in data bits 1..0.
- R4: With `just_right` = 1, a read of the lower address returns result bits 7..0.
- R5: When the interlock is open, a `conv_done` strobe loads `conv_value` on that clock edge, and the next read returns the new value.
- R6: An upper-address read closes the interlock on its clock edge. Strobes in the same cycle as that read, or in any later cycle before the lower-address read, are discarded and the held value is kept.
- R7: A lower-address read opens the interlock on its clock edge. A strobe in that same cycle is accepted.
- R8: A lower-address read with the interlock open returns the current value and leaves the interlock open.
- R9: A change of `just_right` while the interlock is closed remaps the held value at once, on the next read of either byte.
- R10: Reset opens the interlock and does not clear the stored result.
- R11: `rd_data` is 0 when `rd_en` is low or `rd_addr` matches neither register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the interlock |
| just_right | input | 1 | 0 = left-justified, 1 = right-justified |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| conv_value | input | RES_W | Result of the completed conversion |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | 8 | Bus read data, combinational |

## Verification
The bench builds the block with its default parameters: a 10-bit result, an 8-bit address and the upper byte at 0x20. At that width the whole code space is small. Every one of the 1024 codes is loaded and read back through both bytes in both justification modes. This covers every bit position, including the zero padding, against values that the bench computes arithmetically. The interlock cases use marked bit patterns, so that a discarded or a wrongly accepted result shows up in the data read back. These cases are: strobes in the same cycle as each read, strobes between the two reads, a lower-byte read on its own, a mode change while the interlock is closed, and reset with the interlock closed.

// File: rtl/adc_result_pair.sv
module adc_result_pair #(
  parameter int RES_W = 10,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              just_right,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int BYTE_W = 8;
  localparam int TOP_W = RES_W - BYTE_W;
  localparam int PAD_W = 2 * BYTE_W - RES_W;
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] LO_ADDR = BASE_ADDR + 1'b1;

  logic [RES_W-1:0] res_q;
  logic             lock_q;

  wire hi_rd = rd_en && (rd_addr == HI_ADDR);
  wire lo_rd = rd_en && (rd_addr == LO_ADDR);
  wire take  = conv_done && !hi_rd && (!lock_q || lo_rd);

  always_ff @(posedge clk) begin
    if (take) res_q <= conv_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (hi_rd) lock_q <= 1'b1;
    else if (lo_rd) lock_q <= 1'b0;
  end

  wire [BYTE_W-1:0] left_hi  = res_q[RES_W-1 -: BYTE_W];
  wire [BYTE_W-1:0] left_lo  = {res_q[TOP_W-1:0], {PAD_W{1'b0}}};
  wire [BYTE_W-1:0] right_hi = {{PAD_W{1'b0}}, res_q[RES_W-1:BYTE_W]};
  wire [BYTE_W-1:0] right_lo = res_q[BYTE_W-1:0];

  assign rd_data = hi_rd ? (just_right ? right_hi : left_hi) :
                   lo_rd ? (just_right ? right_lo : left_lo) :
                   '0;

  p_hi_read_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> lock_q);

  p_locked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !lo_rd) |=> $stable(res_q));

  p_lo_read_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> !lock_q);

  p_open_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !lock_q && !hi_rd) |=> (res_q == $past(conv_value)));

  p_unlock_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && lo_rd) |=> (res_q == $past(conv_value)));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/adc_result_pair_tb_top.sv
`timescale 1ns/1ps
module adc_result_pair_tb_top;
  localparam logic [7:0] HI = 8'h20;
  localparam logic [7:0] LO = 8'h21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic just_right = 1'b0;
  logic conv_done = 1'b0;
  logic [9:0] conv_value = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_result_pair dut_i (
    .clk(clk), .rst_n(rst_n), .just_right(just_right), .conv_done(conv_done),
    .conv_value(conv_value), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] expect_byte(input logic [9:0] v, input logic right, input logic low);
    int n;
    n = int'(v);
    if (!right) return low ? 8'((n % 4) * 64) : 8'(n / 4);
    return low ? 8'(n % 256) : 8'(n / 256);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic load(input logic [9:0] v);
    @(negedge clk);
    conv_done = 1'b1; conv_value = v;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic strobe, input logic [9:0] v, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    conv_done = strobe; conv_value = v;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R11 idle after reset", rd_data, 8'h00);

    for (int m = 0; m < 2; m++) begin
      just_right = m[0];
      for (int v = 0; v < 1024; v++) begin
        load(10'(v));
        rd(HI, 1'b0, '0, d);
        check(m ? "R3 right upper" : "R1 left upper", d, expect_byte(10'(v), m[0], 1'b0));
        rd(LO, 1'b0, '0, d);
        check(m ? "R4 right lower" : "R2 left lower", d, expect_byte(10'(v), m[0], 1'b1));
      end
    end

    just_right = 1'b1;
    load(10'h155);
    rd(LO, 1'b0, '0, d);
    check("R8 lower alone current", d, 8'h55);
    load(10'h2AA);
    rd(HI, 1'b0, '0, d);
    check("R8 lock stays open", d, 8'h02);
    rd(LO, 1'b0, '0, d);
    check("R5 new value lower", d, 8'hAA);

    load(10'h1C3);
    rd(HI, 1'b0, '0, d);
    check("R6 upper of held", d, 8'h01);
    load(10'h23C);
    load(10'h0F0);
    rd(LO, 1'b0, '0, d);
    check("R6 strobes dropped", d, 8'hC3);
    rd(HI, 1'b0, '0, d);
    check("R6 upper still held", d, 8'h01);
    rd(LO, 1'b0, '0, d);

    rd(HI, 1'b1, 10'h3FF, d);
    check("R6 same-cycle upper", d, 8'h01);
    rd(LO, 1'b0, '0, d);
    check("R6 same-cycle strobe dropped", d, 8'hC3);

    rd(HI, 1'b0, '0, d);
    rd(LO, 1'b1, 10'h2E7, d);
    check("R7 lower before release", d, 8'hC3);
    rd(HI, 1'b0, '0, d);
    check("R7 strobe at release upper", d, 8'h02);
    rd(LO, 1'b0, '0, d);
    check("R7 strobe at release lower", d, 8'hE7);
    load(10'h111);
    rd(HI, 1'b0, '0, d);
    check("R7 open after release", d, 8'h01);
    rd(LO, 1'b0, '0, d);

    just_right = 1'b0;
    load(10'h2D6);
    rd(HI, 1'b0, '0, d);
    check("R9 left upper", d, 8'hB5);
    just_right = 1'b1;
    load(10'h001);
    rd(LO, 1'b0, '0, d);
    check("R9 remapped lower", d, 8'hD6);
    rd(HI, 1'b0, '0, d);
    check("R9 remapped upper", d, 8'h02);
    just_right = 1'b0;
    rd(LO, 1'b0, '0, d);
    check("R9 back to left lower", d, 8'h80);

    load(10'h3A5);
    do_reset();
    rd(HI, 1'b0, '0, d);
    check("R10 result kept", d, 8'hE9);
    do_reset();
    load(10'h05A);
    rd(HI, 1'b0, '0, d);
    check("R10 lock cleared", d, 8'h16);
    rd(LO, 1'b0, '0, d);
    check("R10 lower after reset", d, 8'h80);

    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h22;
    #1 check("R11 other address", rd_data, 8'h00);
    rd_addr = 8'h1F;
    #1 check("R11 address below", rd_data, 8'h00);
    rd_en = 1'b0; rd_addr = HI;
    #1 check("R11 no strobe", rd_data, 8'h00);
    @(negedge clk);
    rd_addr = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule